// File: doc/BRIEF.md
# Two-Latch Edge-Capture Flip-Flop with Forcing Controls

This block is a one-bit storage element made from two level-sensitive latches in series. The first latch, the master, is open during one clock phase. The second latch, the slave, is open during the other phase. Because the two latches are never open together, data moves from the input to the output only at one clock edge. By default that edge is the rising one, and a build parameter can choose the falling edge instead.

Two active-low asynchronous controls override the clocked path. One forces the stored bit to 1 and the other forces it to 0. Both act on both latches at once, so they take effect at any clock level. A toggle input routes the inverted stored bit back to the data path, so the output inverts on every capturing edge and divides the clock by two. The master latch output is brought out for debug.

Top module: `ms_dff`

## Requirements
- R1: With both controls high and `toggle_en_i` low, `q_o` takes the value `d_i` held just before the capturing edge, and keeps it until the next capturing edge. The capturing edge is the rising edge when `POLARITY_RISE` is 1.
- R2: Changes on `d_i` between capturing edges never reach `q_o` or `qn_o`, whether the clock is high or low at the time.
- R3: `preset_ni` low with `clear_ni` high forces `q_o`=1 and `qn_o`=0 at once, at any clock level.
- R4: `clear_ni` low with `preset_ni` high forces `q_o`=0 and `qn_o`=1 at once, at any clock level.
- R5: With both controls low, `q_o` and `qn_o` are both 1. The stored bit is 0 in this state (clear wins inside the latches), so once both controls return high the outputs read `q_o`=0 and `qn_o`=1 until the next capturing edge.
- R6: A capturing edge that occurs while either control is low has no effect. After the controls are released, the forced value stays on the outputs until the next capturing edge.
- R7: Outside the case where both controls are low, `qn_o` is always the inverse of `q_o`.
- R8: With `toggle_en_i` high and both controls high, `q_o` inverts on every capturing edge and `d_i` is ignored.
- R9: With `POLARITY_RISE`=0, capture, hold and toggle behave as in R1, R2 and R8, except that the capturing edge is the falling clock edge.
- R10: `master_q_o` follows the selected data while the master is open, and holds while it is closed. The selected data is `d_i`, or the inverted stored bit in toggle mode. The master is open while the clock is low for a rising-edge build and while it is high for a falling-edge build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both latches are enabled from it in opposite phases |
| d_i | input | 1 | Data to be captured |
| toggle_en_i | input | 1 | When high, the inverted stored bit replaces `d_i` |
| preset_ni | input | 1 | Asynchronous force-to-one, active low |
| clear_ni | input | 1 | Asynchronous force-to-zero, active low; has priority inside the latches |
| q_o | output | 1 | Stored bit |
| qn_o | output | 1 | Complement of the stored bit (both outputs are 1 when both controls are low) |
| master_q_o | output | 1 | Master latch output, for debug |

## Verification
The clocked properties assume that `d_i`, `toggle_en_i` and the two controls never change at the same moment as a clock edge. They also assume that a control, once asserted, stays asserted until after the next sampling edge, so that a pulse never starts and ends between two samples. The stimulus respects this: it changes controls and toggle mode only a short time after the rising edge, and changes data only a short time after each edge. Every asserted control is held for a whole clock period, which spans both edges. A rising-edge build and a falling-edge build are driven from the same stimulus and compared with reference models in the bench.

// File: rtl/ms_dff_pkg.sv
package ms_dff_pkg;

  // Bit 1: clear is active, bit 0: preset is active.
  typedef enum logic [1:0] {
    FORCE_NONE = 2'b00,
    FORCE_ONE  = 2'b01,
    FORCE_ZERO = 2'b10,
    FORCE_BOTH = 2'b11
  } force_e;

  function automatic force_e decode_force(input logic preset_n, input logic clear_n);
    return force_e'({~clear_n, ~preset_n});
  endfunction

endpackage

// File: rtl/ms_dff_force.sv
module ms_dff_force
  import ms_dff_pkg::*;
(
  input  logic   preset_ni,
  input  logic   clear_ni,
  output force_e mode_o,
  output logic   set_o,
  output logic   clr_o
);

  assign mode_o = decode_force(preset_ni, clear_ni);

  // Inside the latches clear wins, so the stored bit is 0 when both are active.
  always_comb begin
    set_o = 1'b0;
    clr_o = 1'b0;
    unique case (mode_o)
      FORCE_ONE:  set_o = 1'b1;
      FORCE_ZERO: clr_o = 1'b1;
      FORCE_BOTH: clr_o = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/ms_dff_latch.sv
module ms_dff_latch #(
  parameter bit OPEN_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic d_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // The clock level is compared here and not in a separate wire. This keeps
  // both latches reacting to the clock in the same step.
  always_latch begin
    if (clr_i)                 q_o = 1'b0;
    else if (set_i)            q_o = 1'b1;
    else if (clk_i == OPEN_LVL) q_o = d_i;
  end

endmodule

// File: rtl/ms_dff_outstage.sv
module ms_dff_outstage
  import ms_dff_pkg::*;
(
  input  force_e mode_i,
  input  logic   slave_q_i,
  output logic   q_o,
  output logic   qn_o
);

  always_comb begin
    if (mode_i == FORCE_BOTH) begin
      q_o  = 1'b1;
      qn_o = 1'b1;
    end else begin
      q_o  = slave_q_i;
      qn_o = ~slave_q_i;
    end
  end

endmodule

// File: rtl/ms_dff.sv
module ms_dff
  import ms_dff_pkg::*;
#(
  parameter bit POLARITY_RISE = 1'b1
) (
  input  logic clk_i,
  input  logic d_i,
  input  logic toggle_en_i,
  input  logic preset_ni,
  input  logic clear_ni,
  output logic q_o,
  output logic qn_o,
  output logic master_q_o
);

  localparam bit MASTER_OPEN = POLARITY_RISE ? 1'b0 : 1'b1;
  localparam bit SLAVE_OPEN  = ~MASTER_OPEN;

  force_e mode;
  logic   set_a;
  logic   clr_a;
  logic   master_q;
  logic   slave_q;
  logic   d_sel;

  ms_dff_force u_force (
    .preset_ni (preset_ni),
    .clear_ni  (clear_ni),
    .mode_o    (mode),
    .set_o     (set_a),
    .clr_o     (clr_a)
  );

  assign d_sel = toggle_en_i ? ~slave_q : d_i;

  ms_dff_latch #(.OPEN_LVL(MASTER_OPEN)) u_master (
    .clk_i (clk_i),
    .d_i   (d_sel),
    .set_i (set_a),
    .clr_i (clr_a),
    .q_o   (master_q)
  );

  ms_dff_latch #(.OPEN_LVL(SLAVE_OPEN)) u_slave (
    .clk_i (clk_i),
    .d_i   (master_q),
    .set_i (set_a),
    .clr_i (clr_a),
    .q_o   (slave_q)
  );

  ms_dff_outstage u_out (
    .mode_i    (mode),
    .slave_q_i (slave_q),
    .q_o       (q_o),
    .qn_o      (qn_o)
  );

  assign master_q_o = master_q;

  logic ctl_act;
  assign ctl_act = ~preset_ni | ~clear_ni;

  if (POLARITY_RISE) begin : g_rise
    // R1
    d_capture_chk: assert property (@(posedge clk_i) disable iff (ctl_act)
      !toggle_en_i |=> q_o == $past(d_i));
    // R8
    toggle_flip_chk: assert property (@(posedge clk_i) disable iff (ctl_act)
      toggle_en_i |=> q_o != $past(q_o));
    // R10
    slave_tracks_master_chk: assert property (@(negedge clk_i) disable iff (ctl_act)
      q_o == master_q_o);
    // R7
    complement_chk: assert property (@(posedge clk_i) disable iff (ctl_act)
      qn_o == ~q_o);
  end else begin : g_fall
    // R9
    d_capture_chk: assert property (@(negedge clk_i) disable iff (ctl_act)
      !toggle_en_i |=> q_o == $past(d_i));
    // R9
    toggle_flip_chk: assert property (@(negedge clk_i) disable iff (ctl_act)
      toggle_en_i |=> q_o != $past(q_o));
    // R10
    slave_tracks_master_chk: assert property (@(posedge clk_i) disable iff (ctl_act)
      q_o == master_q_o);
    // R7
    complement_chk: assert property (@(negedge clk_i) disable iff (ctl_act)
      qn_o == ~q_o);
  end

  // R5
  both_high_chk: assert property (@(posedge clk_i) disable iff (1'b0)
    (!preset_ni && !clear_ni) |-> (q_o && qn_o));

endmodule

// File: tb/ms_dff_bench.sv
module ms_dff_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int N_RANDOM   = 800;

  logic clk = 1'b0;
  logic d = 1'b0, tog = 1'b0, pre_n = 1'b1, clr_n = 1'b0;
  logic qr, qnr, mr, qf, qnf, mf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  ms_dff #(.POLARITY_RISE(1'b1)) u_ms_dff (
    .clk_i(clk), .d_i(d), .toggle_en_i(tog), .preset_ni(pre_n), .clear_ni(clr_n),
    .q_o(qr), .qn_o(qnr), .master_q_o(mr)
  );

  ms_dff #(.POLARITY_RISE(1'b0)) u_ms_dff_fall (
    .clk_i(clk), .d_i(d), .toggle_en_i(tog), .preset_ni(pre_n), .clear_ni(clr_n),
    .q_o(qf), .qn_o(qnf), .master_q_o(mf)
  );

  // Reference stored bits: forcing controls first, then edge capture.
  logic ref_r = 1'b0, ref_f = 1'b0;
  logic last_clk_r = 1'b0, last_clk_f = 1'b0;

  always @(clk or pre_n or clr_n) begin
    if (!clr_n)                 ref_r = 1'b0;
    else if (!pre_n)            ref_r = 1'b1;
    else if (clk && !last_clk_r) ref_r = tog ? ~ref_r : d;
    last_clk_r = clk;
  end

  always @(clk or pre_n or clr_n) begin
    if (!clr_n)                 ref_f = 1'b0;
    else if (!pre_n)            ref_f = 1'b1;
    else if (!clk && last_clk_f) ref_f = tog ? ~ref_f : d;
    last_clk_f = clk;
  end

  function automatic logic exp_q(input logic st);
    return (!pre_n && !clr_n) ? 1'b1 : st;
  endfunction

  function automatic logic exp_qn(input logic st);
    return (!pre_n && !clr_n) ? 1'b1 : ~st;
  endfunction

  function automatic logic exp_master(input logic st);
    return (!pre_n || !clr_n) ? st : (tog ? ~st : d);
  endfunction

  function automatic string tag(input bit fall);
    if (!pre_n && !clr_n) return "R5";
    if (!pre_n)           return "R3";
    if (!clr_n)           return "R4";
    if (fall)             return "R9";
    if (tog)              return "R8";
    return "R1";
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    check(tag(0), qr, exp_q(ref_r));
    check((!pre_n && !clr_n) ? "R5" : "R7", qnr, exp_qn(ref_r));
    check(tag(1), qf, exp_q(ref_f));
    check((!pre_n && !clr_n) ? "R5" : "R7", qnf, exp_qn(ref_f));
  endtask

  // Controls and toggle change shortly after the rising edge, data after each edge.
  task automatic run_cycle(input logic nd1, input logic nd2, input logic ntog,
                           input logic npre, input logic nclr);
    @(posedge clk);
    #2 d = nd1; tog = ntog; pre_n = npre; clr_n = nclr;
    #1 check_outs();
    check("R10", mf, exp_master(ref_f));
    @(negedge clk);
    #1 d = nd2;
    #1 check_outs();
    check("R10", mr, exp_master(ref_r));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24601));

    // R4 reset state: held clear across several edges
    repeat (3) run_cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R4", qr, 1'b0);
    check("R4", qnr, 1'b1);

    // R6: release clear; the forced 0 stays until the next rising edge
    @(posedge clk);
    #2 clr_n = 1'b1; d = 1'b1;
    #1 check("R6", qr, 1'b0);
    @(negedge clk);
    #1 check("R6", qr, 1'b0);
    @(posedge clk);
    #1 check("R1", qr, 1'b1);

    // R2: wiggle data during both clock phases, output must hold
    #1 d = 1'b0;
    #1 d = 1'b1;
    #1 d = 1'b0;
    check("R2", qr, 1'b1);
    @(negedge clk);
    #1 check("R2", qf, 1'b0);
    d = 1'b1;
    #1 d = 1'b0;
    #1 d = 1'b1;
    check("R2", qr, 1'b1);
    check("R2", qf, 1'b0);

    // R3: preset asserted while clock is low acts immediately
    @(negedge clk);
    #1 pre_n = 1'b0;
    #1 check("R3", qr, 1'b1);
    check("R3", qnr, 1'b0);
    check("R3", qf, 1'b1);

    // R5: both low, then release; stored bit is 0
    @(posedge clk);
    #2 clr_n = 1'b0; d = 1'b1;
    #1 check("R5", qr, 1'b1);
    check("R5", qnr, 1'b1);
    @(posedge clk);
    #2 clr_n = 1'b1; pre_n = 1'b1;
    #1 check("R5", qr, 1'b0);
    check("R5", qnr, 1'b1);
    check("R5", qf, 1'b0);

    // R8: toggle run, data held opposite to catch a missing toggle
    for (int i = 0; i < 8; i++) run_cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);

    // Random mix
    for (int i = 0; i < N_RANDOM; i++) begin
      int r;
      logic np, nc;
      r  = int'($urandom % 16);
      np = (r == 0 || r == 2) ? 1'b0 : 1'b1;
      nc = (r == 1 || r == 2) ? 1'b0 : 1'b1;
      run_cycle(1'($urandom), 1'($urandom), ($urandom % 4) == 0, np, nc);
    end

    finish_run();
  end

endmodule